// File: doc/BRIEF.md
# Strided Vector Load Unit over Interleaved Banks

This block reads a vector of up to 64 words from a memory built out of eight interleaved banks and writes them, in element order, into a local vector register buffer. A single start pulse supplies the base word address, a stride and an element count. Element `i` is read from word address `base + i*stride`, computed modulo 2^32. The low three bits of that address select the bank. A bank cannot take a new access for six cycles after it accepts one. The unit sends at most one request per cycle, strictly in element order. When the next element targets a bank that is still recovering, the unit stalls until that bank is free.

Each bank answers a fixed twelve cycles after accepting a request. The unit keeps an internal pipeline of element tags that is as deep as this latency, so it knows which buffer slot each returning word belongs to. A cycle counter measures the run from the accepting clock edge to the edge that writes the last element. A stride of 1 therefore finishes in `vlen + 12` cycles. A stride of 32 or 0 sends every element to one bank and takes `6*(vlen-1) + 13` cycles.

The control is a four-state machine:
- `ST_IDLE`: the state after reset.
  - Goes to `ST_ISSUE` on start with a non-zero length.
  - Goes to `ST_FINISH` on start with length zero.
- `ST_ISSUE`: sends requests.
  - Goes to `ST_DRAIN` in the cycle its last request is accepted.
- `ST_DRAIN`: waits for the outstanding responses.
  - Goes to `ST_FINISH` on the edge that writes the last element.
- `ST_FINISH`: holds `done` high.
  - Goes to `ST_ISSUE` or stays in `ST_FINISH` on the next start, under the same rule as `ST_IDLE`.

Top module: `vld_strided_load`

## Requirements
- R1: The bank of a request is bits [2:0] of its word address. The request raises only that bit of `bank_req` and drives the full word address on `bank_addr`.
- R2: The k-th request of a run carries address `base + k*stride` modulo 2^32. Exactly `vlen` requests are made, and at most one `bank_req` bit is high in any cycle.
- R3: After a bank accepts a request, it receives no further request for the next 5 cycles. Its next possible acceptance is 6 cycles later.
- R4: An element whose bank is busy waits, and every later element waits behind it. Element k is accepted at cycle max(t(k-1)+1, t_last_on_bank+6), where cycle 1 is the first edge after the start edge.
- R5: The word returned by the bank for element i is stored in buffer slot i. `rd_data` shows slot `rd_idx`.
- R6: With a stride that never revisits a bank within 6 elements (for example 1 or 3), requests go out on consecutive cycles. A 64-element load reports 76 cycles.
- R7: With stride 32 or stride 0, all elements hit one bank and are spaced 6 cycles apart. A 64-element load reports 391 cycles.
- R8: `cycles` counts the clock edges from the edge that accepts start up to and including the edge that writes the last element. It holds that value while `done` is high.
- R9: `done` rises on the edge that writes the last element and stays high until the next accepted start. `busy` is high while a run is in progress. A start pulse during a run is ignored.
- R10: A start with `vlen` = 0 makes no requests and sets `done` on the next edge, with `cycles` = 0.
- R11: After reset, `busy` and `done` are low, `cycles` is 0 and no bank request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Starts a load when not busy |
| base | input | 32 | Word address of element 0 |
| stride | input | 32 | Address step between elements (two's complement) |
| vlen | input | 7 | Element count, 0..64; larger values are clamped to 64 |
| bank_req | output | 8 | One-hot request to a bank |
| bank_addr | output | 32 | Word address of the current request |
| bank_rvalid | input | 8 | Per-bank response valid |
| bank_rdata | input | 256 | Per-bank response words; bank b uses bits [32b+31:32b] |
| rd_idx | input | 6 | Buffer read index |
| rd_data | output | 32 | Buffer word at `rd_idx` |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last element written |
| cycles | output | 16 | Cycle count of the last run |

## Verification
Each kind of internal fault shows up at the ports in a predictable way:
- A bank recovery counter that is off by one shifts the cycle of the first stalled request. The issue-cycle log catches this at the next revisit of that bank, and the final `cycles` value differs by the accumulated error.
- A wrong running address shows on `bank_addr` with the very next request.
- A misaligned tag pipeline either stores a word in the wrong slot or fails to see a response. The first case appears when the buffer is read back. The second leaves `done` low forever, which the watchdog reports.
- A state machine that leaves `ST_ISSUE` too early or too late changes the number of requests logged in that run.

// File: rtl/vld_pkg.sv
package vld_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_FINISH = 2'd3
    } vld_state_e;
endpackage

// File: rtl/vld_bank_timer.sv
// Per-bank recovery counters: a bank is free when its counter is zero.
module vld_bank_timer #(
    parameter int NBANK = 8,
    parameter int BUSY  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     take,
    input  logic [$clog2(NBANK)-1:0] take_bank,
    output logic [NBANK-1:0]         free
);
    localparam int BW = $clog2(NBANK);
    localparam int CW = $clog2(BUSY + 1);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [CW-1:0] ctr;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctr <= '0;
            end else if (take && take_bank == BW'(g)) begin
                ctr <= CW'(BUSY - 1);
            end else if (ctr != '0) begin
                ctr <= ctr - 1'b1;
            end
        end
        assign free[g] = (ctr == '0);
    end
endmodule

// File: rtl/vld_tag_pipe.sv
// Delay line carrying element tags for the fixed memory latency.
module vld_tag_pipe #(
    parameter int DEPTH = 12,
    parameter int TW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [TW-1:0] in_tag,
    output logic          out_valid,
    output logic [TW-1:0] out_tag
);
    logic [DEPTH-1:0] vld_q;
    logic [TW-1:0]    tag_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q[0] <= in_valid;
            for (int k = 1; k < DEPTH; k++) begin
                vld_q[k] <= vld_q[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        tag_q[0] <= in_tag;
        for (int k = 1; k < DEPTH; k++) begin
            tag_q[k] <= tag_q[k-1];
        end
    end

    assign out_valid = vld_q[DEPTH-1];
    assign out_tag   = tag_q[DEPTH-1];
endmodule

// File: rtl/vld_elem_buf.sv
// Vector register buffer: one write port, one combinational read port.
module vld_elem_buf #(
    parameter int DEPTH = 64,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/vld_strided_load.sv
module vld_strided_load #(
    parameter int NBANK  = 8,
    parameter int BUSY   = 6,
    parameter int LAT    = 12,
    parameter int VL_MAX = 64,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [ADDR_W-1:0]         base,
    input  logic [ADDR_W-1:0]         stride,
    input  logic [$clog2(VL_MAX+1)-1:0] vlen,
    output logic [NBANK-1:0]          bank_req,
    output logic [ADDR_W-1:0]         bank_addr,
    input  logic [NBANK-1:0]          bank_rvalid,
    input  logic [NBANK*DATA_W-1:0]   bank_rdata,
    input  logic [$clog2(VL_MAX)-1:0] rd_idx,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      busy,
    output logic                      done,
    output logic [CNT_W-1:0]          cycles
);
    import vld_pkg::*;

    localparam int BANK_W = $clog2(NBANK);
    localparam int IDX_W  = $clog2(VL_MAX);
    localparam int LEN_W  = $clog2(VL_MAX + 1);
    localparam int TAG_W  = IDX_W + BANK_W;

    vld_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, stride_q;
    logic [LEN_W-1:0]  vlen_q, issued_q, written_q, vlen_eff;
    logic [CNT_W-1:0]  cyc_q;
    logic [NBANK-1:0]  bank_free;
    logic [BANK_W-1:0] cur_bank, tail_bank;
    logic [IDX_W-1:0]  tail_idx;
    logic [TAG_W-1:0]  tail_tag;
    logic              tail_valid;
    logic              accept, fire, last_issue, wr_fire, last_write;
    logic [DATA_W-1:0] wr_data;

    assign vlen_eff   = (vlen > LEN_W'(VL_MAX)) ? LEN_W'(VL_MAX) : vlen;
    assign cur_bank   = addr_q[BANK_W-1:0];
    assign accept     = (state_q == ST_IDLE || state_q == ST_FINISH) && start;
    assign fire       = (state_q == ST_ISSUE) && bank_free[cur_bank];
    assign last_issue = fire && (issued_q == vlen_q - LEN_W'(1));
    assign tail_idx   = tail_tag[TAG_W-1:BANK_W];
    assign tail_bank  = tail_tag[BANK_W-1:0];
    assign wr_fire    = tail_valid && bank_rvalid[tail_bank];
    assign last_write = wr_fire && (written_q == vlen_q - LEN_W'(1));
    assign wr_data    = bank_rdata[tail_bank*DATA_W +: DATA_W];

    vld_bank_timer #(.NBANK(NBANK), .BUSY(BUSY)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (fire),
        .take_bank (cur_bank),
        .free      (bank_free)
    );

    vld_tag_pipe #(.DEPTH(LAT), .TW(TAG_W)) i_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (fire),
        .in_tag    ({issued_q[IDX_W-1:0], cur_bank}),
        .out_valid (tail_valid),
        .out_tag   (tail_tag)
    );

    vld_elem_buf #(.DEPTH(VL_MAX), .DW(DATA_W)) i_buf (
        .clk   (clk),
        .we    (wr_fire),
        .waddr (tail_idx),
        .wdata (wr_data),
        .raddr (rd_idx),
        .rdata (rd_data)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                if (start) state_d = (vlen_eff == '0) ? ST_FINISH : ST_ISSUE;
            end
            ST_ISSUE: begin
                if (last_issue) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (last_write) state_d = ST_FINISH;
            end
        endcase
    end

    // State register and run bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            stride_q  <= '0;
            vlen_q    <= '0;
            issued_q  <= '0;
            written_q <= '0;
            cyc_q     <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q    <= base;
                stride_q  <= stride;
                vlen_q    <= vlen_eff;
                issued_q  <= '0;
                written_q <= '0;
                cyc_q     <= '0;
            end else begin
                if (state_q == ST_ISSUE || state_q == ST_DRAIN) begin
                    cyc_q <= cyc_q + 1'b1;
                end
                if (fire) begin
                    addr_q   <= addr_q + stride_q;
                    issued_q <= issued_q + 1'b1;
                end
                if (wr_fire) begin
                    written_q <= written_q + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        bank_req  = '0;
        bank_addr = addr_q;
        busy      = 1'b0;
        done      = 1'b0;
        cycles    = cyc_q;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ISSUE: begin
                busy = 1'b1;
                if (fire) bank_req[cur_bank] = 1'b1;
            end
            ST_DRAIN:  busy = 1'b1;
            ST_FINISH: done = 1'b1;
        endcase
    end
endmodule

// File: rtl/vld_checker.sv
module vld_checker #(
    parameter int NBANK  = 8,
    parameter int BUSY   = 6,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [NBANK-1:0]  bank_req,
    input logic [ADDR_W-1:0] bank_addr,
    input logic              busy,
    input logic              done,
    input logic [CNT_W-1:0]  cycles
);
    localparam int BW = $clog2(NBANK);
    localparam int CW = $clog2(BUSY + 1);

    a_r2_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_req));

    a_r1_bank_of_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_req != '0) |-> bank_req[bank_addr[BW-1:0]]);

    a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bank_req == '0));

    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r9_run_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r8_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(cycles));

    // R3: a watch counter per bank measures the gap seen on the request port
    for (genvar g = 0; g < NBANK; g++) begin : g_gap
        logic [CW-1:0] gap;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           gap <= '0;
            else if (bank_req[g]) gap <= CW'(BUSY - 1);
            else if (gap != '0)   gap <= gap - 1'b1;
        end
        a_r3_bank_rest: assert property (@(posedge clk) disable iff (!rst_n)
            bank_req[g] |-> (gap == '0));
    end
endmodule

bind vld_strided_load vld_checker #(
    .NBANK(NBANK), .BUSY(BUSY), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) i_vld_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bank_req  (bank_req),
    .bank_addr (bank_addr),
    .busy      (busy),
    .done      (done),
    .cycles    (cycles)
);

// File: tb/test_vld_strided_load.sv
module test_vld_strided_load;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8, BUSY = 6, LAT = 12, VLM = 64;
    localparam int AW = 32, DW = 32, LW = 7, IW = 6, CW = 16;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] base = '0, stride = '0;
    logic [LW-1:0] vlen = '0;
    logic [NB-1:0] bank_req, bank_rvalid;
    logic [AW-1:0] bank_addr;
    logic [NB*DW-1:0] bank_rdata;
    logic [IW-1:0] rd_idx = '0;
    logic [DW-1:0] rd_data;
    logic busy, done;
    logic [CW-1:0] cycles;

    int checks = 0, fails = 0;
    int edge_n = 0, mark = 0, wd = 0;
    int log_n = 0, viol = 0, multi = 0;
    logic [AW-1:0] log_addr [256];
    int log_bank [256];
    int log_rel [256];
    int last_edge [NB];
    bit seen [NB];

    vld_strided_load i_vld_strided_load (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
        .vlen(vlen), .bank_req(bank_req), .bank_addr(bank_addr),
        .bank_rvalid(bank_rvalid), .bank_rdata(bank_rdata), .rd_idx(rd_idx),
        .rd_data(rd_data), .busy(busy), .done(done), .cycles(cycles)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] dval(input logic [AW-1:0] a);
        return a * 32'h9E3779B1 + 32'h01234567;
    endfunction

    // Behavioural banks: fixed latency, data derived from the address
    logic [LAT-1:0] bv [NB];
    logic [AW-1:0]  ba [NB][LAT];
    always @(posedge clk) begin
        edge_n <= edge_n + 1;
        for (int b = 0; b < NB; b++) begin
            if (!rst_n) begin
                bv[b] <= '0;
            end else begin
                for (int k = LAT-1; k > 0; k--) begin
                    bv[b][k] <= bv[b][k-1];
                    ba[b][k] <= ba[b][k-1];
                end
                bv[b][0] <= bank_req[b];
                ba[b][0] <= bank_addr;
            end
        end
    end
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            bank_rvalid[b] = bv[b][LAT-1];
            bank_rdata[b*DW +: DW] = dval(ba[b][LAT-1]);
        end
    end

    // Request logger (sampled away from the active edge)
    always @(negedge clk) begin
        if (rst_n) begin
            if ($countones(bank_req) > 1) multi++;
            for (int b = 0; b < NB; b++) begin
                if (bank_req[b]) begin
                    if (seen[b] && (edge_n + 1 - last_edge[b]) < BUSY) viol++;
                    seen[b] = 1'b1;
                    last_edge[b] = edge_n + 1;
                    if (log_n < 256) begin
                        log_addr[log_n] = bank_addr;
                        log_bank[log_n] = b;
                        log_rel[log_n]  = edge_n - mark + 1;
                    end
                    log_n++;
                end
            end
        end
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, actual %0d expected done", wd);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic launch(input logic [AW-1:0] b, input logic [AW-1:0] s, input int n);
        @(negedge clk);
        base = b; stride = s; vlen = LW'(n); start = 1'b1;
        log_n = 0; viol = 0; multi = 0; mark = edge_n + 1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // Checks one finished run against a model built from the requirements
    task automatic verify(input logic [AW-1:0] b, input logic [AW-1:0] s,
                          input int n, input string rq_time);
        int free_at [NB];
        int t, tp, aerr, terr, derr;
        logic [AW-1:0] a;
        for (int k = 0; k < NB; k++) free_at[k] = 0;
        tp = 0; aerr = 0; terr = 0; derr = 0;
        for (int i = 0; i < n; i++) begin
            a = b + AW'(i) * s;
            t = (tp + 1 > free_at[a[2:0]]) ? tp + 1 : free_at[a[2:0]];
            free_at[a[2:0]] = t + BUSY;
            tp = t;
            if (i < log_n) begin
                if (log_addr[i] != a || log_bank[i] != int'(a[2:0])) aerr++;
                if (log_rel[i] != t) terr++;
            end
        end
        chk(log_n == n, "R2", "request count", log_n, n);
        chk(multi == 0, "R2", "cycles with several requests", multi, 0);
        chk(aerr == 0, "R1", "address/bank mismatches", aerr, 0);
        chk(viol == 0, "R3", "requests to a resting bank", viol, 0);
        chk(terr == 0, "R4", "issue-cycle mismatches", terr, 0);
        chk(int'(cycles) == tp + LAT, rq_time, "cycle count", cycles, tp + LAT);
        chk(done && !busy, "R9", "done level after run", {busy, done}, 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_idx = IW'(i);
            #1;
            if (rd_data != dval(b + AW'(i) * s)) derr++;
        end
        chk(derr == 0, "R5", "buffer words wrong", derr, 0);
    endtask

    task automatic t_reset();
        #1;
        chk(!busy && !done && cycles == 0 && bank_req == 0, "R11", "reset state",
            {busy, done, cycles, bank_req}, 0);
    endtask

    task automatic t_unit_stride();
        launch(32'h100, 32'd1, 64); wait_done();
        chk(cycles == 76, "R6", "64 elements stride 1", cycles, 76);
        verify(32'h100, 32'd1, 64, "R6");
    endtask

    task automatic t_stride32();
        launch(32'h40, 32'd32, 64); wait_done();
        chk(cycles == 391, "R7", "64 elements stride 32", cycles, 391);
        verify(32'h40, 32'd32, 64, "R7");
    endtask

    task automatic t_stride0();
        launch(32'h7, 32'd0, 9); wait_done();
        chk(cycles == 61, "R7", "9 elements stride 0", cycles, 61);
        verify(32'h7, 32'd0, 9, "R7");
    endtask

    task automatic t_partial_conflict();
        launch(32'h0, 32'd2, 20); wait_done();
        verify(32'h0, 32'd2, 20, "R4");
        launch(32'h20, 32'hFFFF_FFFC, 12); wait_done();
        verify(32'h20, 32'hFFFF_FFFC, 12, "R4");
    endtask

    task automatic t_odd_stride();
        launch(32'h5, 32'd3, 17); wait_done();
        chk(cycles == 29, "R6", "17 elements stride 3", cycles, 29);
        verify(32'h5, 32'd3, 17, "R6");
    endtask

    task automatic t_zero_len();
        launch(32'h300, 32'd1, 0);
        chk(done && cycles == 0, "R10", "zero length done, count", cycles, 0);
        repeat (LAT + 2) @(negedge clk);
        chk(log_n == 0, "R10", "requests for zero length", log_n, 0);
    endtask

    task automatic t_ignore_start();
        launch(32'h200, 32'd1, 30);
        repeat (5) @(negedge clk);
        base = 32'h999; stride = 32'd0; vlen = LW'(3); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(cycles == 42, "R9", "start during run ignored", cycles, 42);
        verify(32'h200, 32'd1, 30, "R9");
    endtask

    task automatic t_hold();
        logic [CW-1:0] c0;
        launch(32'h10, 32'd1, 4); wait_done();
        c0 = cycles;
        repeat (20) @(negedge clk);
        chk(done && cycles == c0, "R8", "count held while done", cycles, c0);
        chk(c0 == 16, "R8", "4 elements stride 1", c0, 16);
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin
            seen[b] = 1'b0;
            last_edge[b] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unit_stride();
        t_stride32();
        t_stride0();
        t_partial_conflict();
        t_odd_stride();
        t_zero_len();
        t_ignore_start();
        t_hold();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule